// File: doc/BRIEF.md
# Protected Fully Associative Translation Buffer

This block turns a 32-bit virtual address into a 28-bit physical address using 64 KB pages, and in the same cycle decides whether the requested kind of access is allowed on that page. The upper 16 bits of the virtual address form the page number. That number is compared at once against every stored entry. The lower 16 bits pass straight through as the page offset. A hit returns the stored 12-bit physical page number joined to the offset. A miss tells the surrounding logic to run its page-table walk. A hit whose access type is not allowed by the entry's permission bits raises a protection trap instead of a usable address.

Once a miss has been serviced, the walker writes the translation through a fill port. A fill first reuses an entry that already holds the same page number. If there is none, it takes the lowest-numbered empty slot. When every slot is in use, it evicts the slot selected by a rotating pointer. A flush input empties the whole buffer at one clock edge, for example on an address-space change. Lookup is purely combinational. Fill and flush take effect on the clock edge.

Top module: `xlat_tlb`

## Requirements
- R1: The physical address output is the 12-bit page number of the matching entry in bits [27:16], followed by virtual address bits [15:0] copied unchanged into bits [15:0].
- R2: With `lk_req` high, `lk_hit` is high exactly when some valid entry holds a page number equal to `lk_va[31:16]`, whatever slot that entry sits in.
- R3: With `lk_req` high and no valid entry matching, `lk_miss` is high and `lk_hit`, `lk_trap` and `lk_pa_vld` are low.
- R4: The access code on `lk_acc` is read=0, write=1, execute=2, reserved=3. The permission field is bit 2 for read, bit 1 for write and bit 0 for execute. A hit whose access lacks its permission bit raises `lk_trap`, and code 3 always traps.
- R5: `lk_pa_vld` is high only on a hit without a trap. With `lk_req` low, all four status outputs are low.
- R6: After reset the buffer holds no valid entry, and the replacement pointer is at slot 0.
- R7: A fill whose page number is not already stored goes into the lowest-numbered invalid slot while one exists, and leaves the replacement pointer unchanged.
- R8: A fill whose page number is not stored, made when all slots are valid, overwrites the slot named by the replacement pointer and then advances the pointer by one, wrapping around.
- R9: A fill whose page number is already in a valid slot rewrites that slot's page number and permissions in place, and does not move the pointer.
- R10: A flush invalidates every entry at one clock edge, and it overrides a fill made in the same cycle.
- R11: A lookup in the same cycle as a fill or flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_req | input | 1 | Lookup strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 reserved |
| lk_pa | output | 28 | Translated physical address |
| lk_pa_vld | output | 1 | Physical address usable (hit, no trap) |
| lk_hit | output | 1 | A valid entry matches |
| lk_miss | output | 1 | No valid entry matches |
| lk_trap | output | 1 | Hit with a forbidden access type |
| fl_en | input | 1 | Fill strobe |
| fl_vpn | input | 16 | Page number to install |
| fl_ppn | input | 12 | Physical page number to install |
| fl_perm | input | 3 | Permissions to install: bit 2 read, bit 1 write, bit 0 execute |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest case to reach is eviction order, because the pointer is invisible and only moves on fills into a full buffer. The stimulus fills all 16 slots in order and then installs new pages one at a time. After each one it looks up which older page has vanished. A refill of an already-present page number is placed between two evictions. The next eviction must then remove the slot after the last one evicted, which shows the refill did not advance the pointer. Same-cycle fill/lookup and flush/fill collisions are also driven in one cycle and checked on the following cycle.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam int PERM_W   = 3;
   localparam int PERM_RD  = 2;
   localparam int PERM_WR  = 1;
   localparam int PERM_EX  = 0;

   function automatic logic perm_allows(input logic [1:0] acc, input logic [PERM_W-1:0] perm);
      logic ok;
      case (acc)
         ACC_READ:  ok = perm[PERM_RD];
         ACC_WRITE: ok = perm[PERM_WR];
         ACC_EXEC:  ok = perm[PERM_EX];
         default:   ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 16,
   parameter int PPN_W   = 12,
   parameter int PERM_W  = 3,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [VPN_W-1:0]                  wr_vpn,
   input  logic [PPN_W-1:0]                  wr_ppn,
   input  logic [PERM_W-1:0]                 wr_perm,
   input  logic                              flush,
   output logic [ENTRIES-1:0]                valid,
   output logic [ENTRIES-1:0][VPN_W-1:0]     vpn_tab,
   output logic [ENTRIES-1:0][PPN_W-1:0]     ppn_tab,
   output logic [ENTRIES-1:0][PERM_W-1:0]    perm_tab
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid[e] <= 1'b0;
         end else if (flush) begin
            valid[e] <= 1'b0;
         end else if (sel) begin
            valid[e] <= 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vpn_tab[e]  <= '0;
            ppn_tab[e]  <= '0;
            perm_tab[e] <= '0;
         end else if (sel && !flush) begin
            vpn_tab[e]  <= wr_vpn;
            ppn_tab[e]  <= wr_ppn;
            perm_tab[e] <= wr_perm;
         end
      end
   end

endmodule

// File: rtl/xlat_tlb_cam.sv
module xlat_tlb_cam #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab,
   input  logic [VPN_W-1:0]              key,
   output logic [ENTRIES-1:0]            match,
   output logic                          any,
   output logic [IDX_W-1:0]              idx
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = valid[e] && (vpn_tab[e] == key);
   end

   assign any = |match;

   always_comb begin
      idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) idx = idx | IDX_W'(e);
      end
   end

endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid,
   input  logic               fill_en,
   input  logic               fill_hit,
   input  logic [IDX_W-1:0]   fill_hit_idx,
   input  logic               flush,
   output logic [IDX_W-1:0]   wr_idx
);

   logic [IDX_W-1:0] rr_ptr;
   logic [IDX_W-1:0] free_idx;
   logic             free_any;
   logic             evict;

   always_comb begin
      free_idx = '0;
      free_any = 1'b0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!valid[e]) begin
            free_idx = IDX_W'(e);
            free_any = 1'b1;
         end
      end
   end

   assign evict  = fill_en && !flush && !fill_hit && !free_any;
   assign wr_idx = fill_hit ? fill_hit_idx : (free_any ? free_idx : rr_ptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr <= '0;
      end else if (evict) begin
         if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
         else                               rr_ptr <= rr_ptr + 1'b1;
      end
   end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int VA_W    = 32,
   parameter int PA_W    = 28,
   parameter int OFS_W   = 16,
   parameter int ENTRIES = 16,
   localparam int VPN_W  = VA_W - OFS_W,
   localparam int PPN_W  = PA_W - OFS_W,
   localparam int PERM_W = xlat_tlb_pkg::PERM_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [1:0]        lk_acc,
   output logic [PA_W-1:0]   lk_pa,
   output logic              lk_pa_vld,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_trap,
   input  logic              fl_en,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [PPN_W-1:0]  fl_ppn,
   input  logic [PERM_W-1:0] fl_perm,
   input  logic              flush
);

   import xlat_tlb_pkg::*;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("xlat_tlb: ENTRIES must be a power of two of at least 2");
   end
   if (OFS_W < 1 || VA_W <= OFS_W || PA_W <= OFS_W) begin : g_bad_widths
      $error("xlat_tlb: address widths must exceed the offset width");
   end

   logic [ENTRIES-1:0]             valid;
   logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab;
   logic [ENTRIES-1:0][PPN_W-1:0]  ppn_tab;
   logic [ENTRIES-1:0][PERM_W-1:0] perm_tab;

   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;
   logic [IDX_W-1:0]   lk_idx;

   logic [ENTRIES-1:0] fl_match;
   logic               fl_any;
   logic [IDX_W-1:0]   fl_idx;
   logic [IDX_W-1:0]   wr_idx;

   xlat_tlb_store #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fl_en), .wr_idx(wr_idx),
      .wr_vpn(fl_vpn), .wr_ppn(fl_ppn), .wr_perm(fl_perm),
      .flush(flush),
      .valid(valid), .vpn_tab(vpn_tab), .ppn_tab(ppn_tab), .perm_tab(perm_tab)
   );

   xlat_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_cam (
      .valid(valid), .vpn_tab(vpn_tab), .key(lk_va[VA_W-1:OFS_W]),
      .match(lk_match), .any(lk_any), .idx(lk_idx)
   );

   xlat_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fl_cam (
      .valid(valid), .vpn_tab(vpn_tab), .key(fl_vpn),
      .match(fl_match), .any(fl_any), .idx(fl_idx)
   );

   xlat_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .valid(valid),
      .fill_en(fl_en), .fill_hit(fl_any), .fill_hit_idx(fl_idx),
      .flush(flush), .wr_idx(wr_idx)
   );

   logic [PPN_W-1:0]  sel_ppn;
   logic [PERM_W-1:0] sel_perm;
   logic              allowed;

   assign sel_ppn  = ppn_tab[lk_idx];
   assign sel_perm = perm_tab[lk_idx];
   assign allowed  = perm_allows(lk_acc, sel_perm);

   assign lk_hit    = lk_req && lk_any;
   assign lk_miss   = lk_req && !lk_any;
   assign lk_trap   = lk_hit && !allowed;
   assign lk_pa_vld = lk_hit && allowed;
   assign lk_pa     = {sel_ppn, lk_va[OFS_W-1:0]};

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 28,
   parameter int OFS_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_req,
   input logic [VA_W-1:0] lk_va,
   input logic [PA_W-1:0] lk_pa,
   input logic            lk_pa_vld,
   input logic            lk_hit,
   input logic            lk_miss,
   input logic            lk_trap,
   input logic            flush
);

   AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      lk_pa_vld |-> (lk_pa[OFS_W-1:0] == lk_va[OFS_W-1:0])); // R1
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |-> (lk_hit != lk_miss)); // R2
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> !(lk_hit || lk_trap || lk_pa_vld)); // R3
   AST_TRAP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_trap |-> (lk_hit && !lk_pa_vld)); // R4
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> !(lk_hit || lk_miss || lk_trap || lk_pa_vld)); // R5
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && rst_n) |=> (lk_req |-> lk_miss)); // R10

endmodule

bind xlat_tlb xlat_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_pa(lk_pa),
   .lk_pa_vld(lk_pa_vld), .lk_hit(lk_hit), .lk_miss(lk_miss),
   .lk_trap(lk_trap), .flush(flush)
);

// File: tb/sim_xlat_tlb.sv
`timescale 1ns/1ps
module sim_xlat_tlb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [31:0] lk_va = '0;
   logic [1:0]  lk_acc = '0;
   logic [27:0] lk_pa;
   logic        lk_pa_vld, lk_hit, lk_miss, lk_trap;
   logic        fl_en = 1'b0;
   logic [15:0] fl_vpn = '0;
   logic [11:0] fl_ppn = '0;
   logic [2:0]  fl_perm = '0;
   logic        flush = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [2:0] P_RX = 3'b101, P_RW = 3'b110, P_R = 3'b100, P_ALL = 3'b111;

   typedef struct {
      string       tag;
      logic        hit, miss, trap, vld;
      logic [27:0] pa;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   xlat_tlb u0 (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_acc(lk_acc),
      .lk_pa(lk_pa), .lk_pa_vld(lk_pa_vld), .lk_hit(lk_hit), .lk_miss(lk_miss),
      .lk_trap(lk_trap), .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn),
      .fl_perm(fl_perm), .flush(flush)
   );

   // drive one cycle: optional lookup, optional fill, optional flush
   task automatic cyc(input bit rq, input logic [31:0] va, input logic [1:0] acc,
                      input bit fe, input logic [15:0] vpn, input logic [11:0] ppn,
                      input logic [2:0] perm, input bit fs);
      @(negedge clk);
      lk_req = rq; lk_va = va; lk_acc = acc;
      fl_en = fe; fl_vpn = vpn; fl_ppn = ppn; fl_perm = perm;
      flush = fs;
   endtask

   task automatic expect_look(input string tag, input logic [31:0] va, input logic [1:0] acc,
                              input bit h, input bit t, input logic [11:0] ppn,
                              input bit fe = 0, input logic [15:0] vpn = '0,
                              input logic [11:0] fppn = '0, input logic [2:0] perm = '0,
                              input bit fs = 0);
      exp_t x;
      cyc(1'b1, va, acc, fe, vpn, fppn, perm, fs);
      x.tag = tag; x.hit = h; x.miss = !h; x.trap = h && t; x.vld = h && !t;
      x.pa = {ppn, va[15:0]};
      sb.push_back(x);
   endtask

   task automatic expect_idle(input string tag);
      exp_t x;
      cyc(1'b0, 32'h1234_0000, 2'd0, 1'b0, '0, '0, '0, 1'b0);
      x.tag = tag; x.hit = 0; x.miss = 0; x.trap = 0; x.vld = 0; x.pa = '0;
      sb.push_back(x);
   endtask

   task automatic fill(input logic [15:0] vpn, input logic [11:0] ppn, input logic [2:0] perm);
      cyc(1'b0, '0, 2'd0, 1'b1, vpn, ppn, perm, 1'b0);
   endtask

   // monitor: compare away from both clock edges
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            n_cmp++;
            if ({lk_hit, lk_miss, lk_trap, lk_pa_vld} != {x.hit, x.miss, x.trap, x.vld} ||
                (x.vld && lk_pa != x.pa)) begin
               n_bad++;
               $display("FAIL %s: hit/miss/trap/vld=%b%b%b%b pa=%h expected %b%b%b%b pa=%h",
                        x.tag, lk_hit, lk_miss, lk_trap, lk_pa_vld, lk_pa,
                        x.hit, x.miss, x.trap, x.vld, x.pa);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6: empty after reset
      expect_look("R6 reset empty", 32'h1234_5678, 2'd0, 0, 0, '0);
      expect_idle("R5 idle quiet");

      // R1 R2 R4 read/exec on RX page, write traps
      fill(16'h1234, 12'hABC, P_RX);
      expect_look("R1 R2 read hit pa", 32'h1234_5678, 2'd0, 1, 0, 12'hABC);
      expect_look("R4 exec on RX ok", 32'h1234_00F0, 2'd2, 1, 0, 12'hABC);
      expect_look("R4 write on RX traps", 32'h1234_0004, 2'd1, 1, 1, 12'hABC);
      expect_look("R4 reserved code traps", 32'h1234_0004, 2'd3, 1, 1, 12'hABC);
      expect_look("R3 other page misses", 32'h1235_5678, 2'd0, 0, 0, '0);

      fill(16'h0002, 12'h111, P_RW);
      expect_look("R4 exec on RW traps", 32'h0002_0010, 2'd2, 1, 1, 12'h111);
      expect_look("R4 write on RW ok", 32'h0002_FFFF, 2'd1, 1, 0, 12'h111);

      // R11: fill with lookup same cycle sees old contents
      expect_look("R11 fill same cycle old", 32'h0003_0000, 2'd0, 0, 0, '0,
                  1, 16'h0003, 12'h333, P_R);
      expect_look("R11 fill visible next", 32'h0003_0022, 2'd0, 1, 0, 12'h333);

      // R7: fill remaining free slots 3..15
      for (int k = 0; k < 13; k++) fill(16'h0100 + 16'(k), 12'h800 + 12'(k), P_ALL);
      expect_look("R7 slot 15 entry", 32'h010C_0000, 2'd1, 1, 0, 12'h80C);
      expect_look("R2 slot 0 still there", 32'h1234_0000, 2'd0, 1, 0, 12'hABC);

      // R8: full, eviction starts at slot 0
      fill(16'h0200, 12'h900, P_ALL);
      expect_look("R8 slot0 evicted", 32'h1234_0000, 2'd0, 0, 0, '0);
      expect_look("R8 new page hit", 32'h0200_0001, 2'd0, 1, 0, 12'h900);
      expect_look("R8 slot1 kept", 32'h0002_0000, 2'd0, 1, 0, 12'h111);
      fill(16'h0201, 12'h901, P_ALL);
      expect_look("R8 slot1 evicted", 32'h0002_0000, 2'd0, 0, 0, '0);

      // R9: refill existing page in place, pointer must stay at slot 2
      fill(16'h0100, 12'hFED, P_R);
      expect_look("R9 in-place ppn", 32'h0100_1234, 2'd0, 1, 0, 12'hFED);
      expect_look("R9 in-place perm", 32'h0100_1234, 2'd1, 1, 1, 12'hFED);
      fill(16'h0202, 12'h902, P_ALL);
      expect_look("R9 pointer held: slot2 evicted", 32'h0003_0000, 2'd0, 0, 0, '0);
      expect_look("R9 slot3 survives", 32'h0100_0000, 2'd0, 1, 0, 12'hFED);

      // R10 R11: flush with fill and lookup in same cycle
      expect_look("R11 flush same cycle old", 32'h0200_0000, 2'd0, 1, 0, 12'h900,
                  1, 16'h0300, 12'h777, P_ALL, 1);
      expect_look("R10 flushed entry", 32'h0200_0000, 2'd0, 0, 0, '0);
      expect_look("R10 flush beats fill", 32'h0300_0000, 2'd0, 0, 0, '0);
      expect_look("R10 later page gone", 32'h0202_0000, 2'd0, 0, 0, '0);

      fill(16'h0400, 12'h444, P_RX);
      expect_look("R7 refill after flush", 32'h0400_0ABC, 2'd2, 1, 0, 12'h444);
      expect_idle("R5 idle after traffic");

      cyc(1'b0, '0, 2'd0, 1'b0, '0, '0, '0, 1'b0);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule